// File: doc/BRIEF.md
# Daisy-Chained PWM Bank with Carrier Modulation

This block is a bank of pulse-width modulation channels whose start times are linked in a chain. A pulse from an external timer match starts the first channel. Each channel passes its own start pulse on to the next one, and every channel adds its own programmable delay before it restarts. If all delays are equal, the channels start at evenly spaced times. If the delays differ, the starts are staggered, which spreads the switching load over time.

Each channel runs a free-running period counter. The channel drives its output high while the counter is below the duty value. That result is then ANDed with the channel's carrier input, so the pin carries the PWM waveform chopped by the carrier. If the carrier source pauses and holds its line low, the output is forced low. If it holds the line high, the plain PWM waveform passes through.

New period and duty values are staged on the inputs. A channel takes them only at the start of a period, and only while the update-enable input is high. This means a waveform already in flight is never cut part-way.

Top module: `cpwm_chain`

## Requirements
- R1: After reset, every `pwm_o` and `sync_o` bit is low. A channel's `pwm_o` stays low until that channel has been restarted by the chain for the first time.
- R2: If `start_i` is high in cycle n, channel 0 restarts with its period counter at 0 in cycle n+1+D0, where D0 is field 0 of `dly_i`. `sync_o[0]` is high in exactly that cycle. A delay of 0 therefore restarts on the cycle after the start pulse.
- R3: If `sync_o[k-1]` is high in cycle m, channel k (k>0) restarts and raises `sync_o[k]` in cycle m+1+Dk. Channels with equal delays therefore start evenly spaced, and unequal delays give staggered starts.
- R4: Each `sync_o` bit is a one-cycle pulse. It appears only on a restart triggered by the chain, never on an ordinary period wrap.
- R5: Once running, channel k with active period P and duty W drives `pwm_o[k]` = ((c - s) mod P) < W AND `carrier_i[k]`, where s is the cycle of its last restart and c is the current cycle.
- R6: A duty of 0 keeps `pwm_o[k]` low for the whole period.
- R7: A duty greater than or equal to the period makes `pwm_o[k]` equal to `carrier_i[k]` in every cycle.
- R8: While `carrier_i[k]` is low, `pwm_o[k]` is low, whatever the counter and duty values.
- R9: A channel copies the `per_i` and `duty_i` fields into its active values only on a cycle that starts a period (a chain restart or a wrap), and only if `upd_en_i` was high in the cycle before that start. Otherwise the active values are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Start pulse for channel 0, taken from the timer match |
| upd_en_i | input | 1 | Allows staged period and duty values to be copied at a period start |
| dly_i | input | NCH*DLY_W | Per-channel restart delay; field k sits at bits [k*DLY_W +: DLY_W] |
| per_i | input | NCH*CNT_W | Staged period per channel, field k at [k*CNT_W +: CNT_W] |
| duty_i | input | NCH*CNT_W | Staged duty per channel, field k at [k*CNT_W +: CNT_W] |
| carrier_i | input | NCH | Carrier per channel; ANDed into the output |
| pwm_o | output | NCH | Modulated PWM outputs |
| sync_o | output | NCH | Per-channel restart pulse, feeding the next channel |

## Verification
The assertions assume that `start_i` is a one-cycle pulse, that consecutive start pulses are at least two cycles apart, and that `dly_i` does not change while any delay countdown is in progress. Under these conditions the chain pulses cannot merge and the zero-delay timing is fixed. The stimulus respects all three rules. It changes the delay and the staged values only after the previous scenario's expected pulses have been observed, and it never holds `start_i` high for more than one cycle.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  typedef enum logic {
    DLY_IDLE  = 1'b0,
    DLY_COUNT = 1'b1
  } dly_state_e;

endpackage

// File: rtl/cpwm_rst_sync.sv
module cpwm_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sn
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sn = sync_q[1];

endmodule

// File: rtl/cpwm_delay.sv
module cpwm_delay
  import cpwm_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_in_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             fire_o
);

  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  dly_state_e       state_q, state_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // next-state: a fresh sync always reloads, even mid-countdown
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    fire_o  = 1'b0;
    cnt_en  = 1'b0;
    if (sync_in_i) begin
      if (dly_i == '0) begin
        fire_o  = 1'b1;
        state_d = DLY_IDLE;
      end else begin
        state_d = DLY_COUNT;
        cnt_d   = dly_i;
        cnt_en  = 1'b1;
      end
    end else if (state_q == DLY_COUNT) begin
      cnt_en = 1'b1;
      if (cnt_q == ONE) begin
        fire_o  = 1'b1;
        state_d = DLY_IDLE;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DLY_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/cpwm_period.sv
module cpwm_period #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             upd_en_i,
  input  logic [CNT_W-1:0] per_new_i,
  input  logic [CNT_W-1:0] duty_new_i,
  input  logic             carrier_i,
  output logic             pwm_o
);

  localparam int EXT_W = CNT_W + 1;

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] duty_q, duty_d;
  logic [EXT_W-1:0] cnt_next_ext;
  logic             wrap;
  logic             per_start;
  logic             shadow_en;
  logic             wave;

  always_comb begin
    cnt_next_ext = {1'b0, cnt_q} + EXT_W'(1);
    wrap         = run_q && (cnt_next_ext >= {1'b0, per_q});
    per_start    = restart_i || wrap;
    shadow_en    = per_start && upd_en_i;
    run_d        = run_q || restart_i;
    if (per_start) begin
      cnt_d = '0;
    end else if (run_q) begin
      cnt_d = cnt_next_ext[CNT_W-1:0];
    end else begin
      cnt_d = cnt_q;
    end
    per_d  = shadow_en ? per_new_i  : per_q;
    duty_d = shadow_en ? duty_new_i : duty_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= '0;
      duty_q <= '0;
    end else if (shadow_en) begin
      per_q  <= per_d;
      duty_q <= duty_d;
    end
  end

  assign wave  = run_q && (cnt_q < duty_q);
  assign pwm_o = wave && carrier_i;

endmodule

// File: rtl/cpwm_chan.sv
module cpwm_chan #(
  parameter int CNT_W = 8,
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_in_i,
  input  logic             upd_en_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             carrier_i,
  output logic             pwm_o,
  output logic             sync_o
);

  logic fire;
  logic sync_q;

  cpwm_delay #(.DLY_W(DLY_W)) u_delay (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_in_i (sync_in_i),
    .dly_i     (dly_i),
    .fire_o    (fire)
  );

  cpwm_period #(.CNT_W(CNT_W)) u_period (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (fire),
    .upd_en_i   (upd_en_i),
    .per_new_i  (per_i),
    .duty_new_i (duty_i),
    .carrier_i  (carrier_i),
    .pwm_o      (pwm_o)
  );

  // restart pulse aligned with the first cycle of the new period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b0;
    end else begin
      sync_q <= fire;
    end
  end

  assign sync_o = sync_q;

endmodule

// File: rtl/cpwm_chain.sv
module cpwm_chain #(
  parameter int NCH   = 4,
  parameter int CNT_W = 8,
  parameter int DLY_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 upd_en_i,
  input  logic [NCH*DLY_W-1:0] dly_i,
  input  logic [NCH*CNT_W-1:0] per_i,
  input  logic [NCH*CNT_W-1:0] duty_i,
  input  logic [NCH-1:0]       carrier_i,
  output logic [NCH-1:0]       pwm_o,
  output logic [NCH-1:0]       sync_o
);

  logic           rst_sn;
  logic [NCH-1:0] chain_in;

  cpwm_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_sn (rst_sn)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    if (k == 0) begin : g_head
      assign chain_in[k] = start_i;
    end else begin : g_link
      assign chain_in[k] = sync_o[k-1];
    end

    cpwm_chan #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_sn),
      .sync_in_i (chain_in[k]),
      .upd_en_i  (upd_en_i),
      .dly_i     (dly_i[k*DLY_W +: DLY_W]),
      .per_i     (per_i[k*CNT_W +: CNT_W]),
      .duty_i    (duty_i[k*CNT_W +: CNT_W]),
      .carrier_i (carrier_i[k]),
      .pwm_o     (pwm_o[k]),
      .sync_o    (sync_o[k])
    );
  end

endmodule

// File: rtl/cpwm_chain_chk.sv
module cpwm_chain_chk #(
  parameter int NCH   = 4,
  parameter int DLY_W = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic [NCH*DLY_W-1:0] dly_i,
  input logic [NCH-1:0]       carrier_i,
  input logic [NCH-1:0]       pwm_o,
  input logic [NCH-1:0]       sync_o
);

  logic [NCH-1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= '0;
    end else begin
      seen_q <= seen_q | sync_o;
    end
  end

  AST_ZERO_DELAY_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (dly_i[DLY_W-1:0] == '0)) |=> sync_o[0]); // R2

  for (genvar k = 0; k < NCH; k++) begin : g_chk
    AST_CARRIER_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !carrier_i[k] |-> !pwm_o[k]); // R8

    AST_SYNC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sync_o[k] |=> !sync_o[k]); // R4

    AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!seen_q[k] && !sync_o[k]) |-> !pwm_o[k]); // R1

    if (k > 0) begin : g_link
      AST_ZERO_DELAY_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sync_o[k-1] && (dly_i[k*DLY_W +: DLY_W] == '0)) |=> sync_o[k]); // R3
    end
  end

endmodule

bind cpwm_chain cpwm_chain_chk #(.NCH(NCH), .DLY_W(DLY_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_sn),
  .start_i   (start_i),
  .dly_i     (dly_i),
  .carrier_i (carrier_i),
  .pwm_o     (pwm_o),
  .sync_o    (sync_o)
);

// File: tb/cpwm_chain_tb_top.sv
module cpwm_chain_tb_top;

  localparam int NCH   = 4;
  localparam int CNT_W = 8;
  localparam int DLY_W = 8;

  typedef struct {
    int    cyc;
    int    ch;
    bit    is_sync;
    bit    val;
    string req;
  } exp_t;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 start = 1'b0;
  logic                 upd_en = 1'b1;
  logic [NCH*DLY_W-1:0] dly = '0;
  logic [NCH*CNT_W-1:0] per = '0;
  logic [NCH*CNT_W-1:0] duty = '0;
  logic [NCH-1:0]       carrier = '1;
  logic [NCH-1:0]       pwm;
  logic [NCH-1:0]       sync;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   car_mode = 1'b0;
  bit   done = 1'b0;
  exp_t q[$];

  int cfg_dly [NCH];
  int cfg_per [NCH];
  int cfg_dut [NCH];

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // carrier: constant high, or toggling every two cycles (bit 1 of the cycle index)
  always @(posedge clk) begin
    #1;
    carrier = car_mode ? {NCH{cyc[1]}} : {NCH{1'b1}};
  end

  cpwm_chain #(.NCH(NCH), .CNT_W(CNT_W), .DLY_W(DLY_W)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .start_i   (start),
    .upd_en_i  (upd_en),
    .dly_i     (dly),
    .per_i     (per),
    .duty_i    (duty),
    .carrier_i (carrier),
    .pwm_o     (pwm),
    .sync_o    (sync)
  );

  // monitor: pops every expectation due in the current cycle
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc == cyc) begin
        logic act;
        act = q[i].is_sync ? sync[q[i].ch] : pwm[q[i].ch];
        n_chk++;
        if (act !== q[i].val) begin
          n_fail++;
          $display("FAIL %s cycle %0d ch%0d %s actual=%0b expected=%0b",
                   q[i].req, cyc, q[i].ch, q[i].is_sync ? "sync" : "pwm", act, q[i].val);
        end
        q.delete(i);
      end
    end
  end

  function automatic bit car_at(int c);
    return car_mode ? bit'((c >> 1) & 1) : 1'b1;
  endfunction

  task automatic push(int c, int ch, bit s, bit v, string r);
    exp_t e;
    e.cyc = c; e.ch = ch; e.is_sync = s; e.val = v; e.req = r;
    q.push_back(e);
  endtask

  task automatic apply_cfg();
    for (int k = 0; k < NCH; k++) begin
      dly[k*DLY_W +: DLY_W]  = DLY_W'(cfg_dly[k]);
      per[k*CNT_W +: CNT_W]  = CNT_W'(cfg_per[k]);
      duty[k*CNT_W +: CNT_W] = CNT_W'(cfg_dut[k]);
    end
  endtask

  // driver: pulse start, push expected sync/pwm for each masked channel
  task automatic run_scn(bit [NCH-1:0] mask, bit pre, int win);
    int n;
    int s;
    @(posedge clk); #1;
    start = 1'b1;
    n = cyc;
    s = n;
    for (int k = 0; k < NCH; k++) begin
      s = s + 1 + cfg_dly[k];   // R2 for k=0, R3 for later links
      if (mask[k]) begin
        for (int c = n + 1; c <= n + win; c++) begin
          push(c, k, 1'b1, c == s, (c == s) ? ((k == 0) ? "R2" : "R3") : "R4");
          if (c < s) begin
            if (pre) push(c, k, 1'b0, 1'b0, "R1");
          end else begin
            bit base;
            bit cr;
            string r;
            base = ((c - s) % cfg_per[k]) < cfg_dut[k];
            cr   = car_at(c);
            if (!cr) r = "R8";
            else if (cfg_dut[k] == 0) r = "R6";
            else if (cfg_dut[k] >= cfg_per[k]) r = "R7";
            else r = "R5";
            push(c, k, 1'b0, base && cr, r);
          end
        end
      end
    end
    @(posedge clk); #1;
    start = 1'b0;
    repeat (win) @(posedge clk);
    wait (q.size() == 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    // R1: idle after reset
    n_chk++;
    if (pwm !== '0 || sync !== '0) begin
      n_fail++;
      $display("FAIL R1 after reset actual=%b/%b expected=0000/0000", pwm, sync);
    end

    // staggered delays, first start, idle check before each restart (R1,R2,R3,R4,R5)
    cfg_dly = '{0, 2, 5, 1};
    cfg_per = '{10, 7, 4, 9};
    cfg_dut = '{3, 2, 1, 4};
    apply_cfg();
    run_scn(4'b1111, 1'b1, 45);

    // equal delays: evenly spaced starts (R3)
    cfg_dly = '{1, 1, 1, 1};
    cfg_per = '{6, 6, 6, 6};
    cfg_dut = '{2, 3, 4, 5};
    apply_cfg();
    run_scn(4'b1111, 1'b0, 30);

    // duty corners and toggling carrier (R6, R7, R8)
    car_mode = 1'b1;
    cfg_dly = '{0, 0, 0, 0};
    cfg_per = '{8, 8, 5, 6};
    cfg_dut = '{3, 0, 12, 6};
    apply_cfg();
    run_scn(4'b1111, 1'b0, 30);
    car_mode = 1'b0;
    repeat (2) @(posedge clk);

    // shadow update on channel 0 (R9)
    cfg_dly = '{0, 0, 0, 0};
    cfg_per = '{10, 8, 8, 8};
    cfg_dut = '{3, 2, 2, 2};
    apply_cfg();
    run_scn(4'b0001, 1'b0, 12);
    begin
      int n;
      int s0;
      @(posedge clk); #1;
      upd_en = 1'b0;
      per[0 +: CNT_W]  = CNT_W'(6);
      duty[0 +: CNT_W] = CNT_W'(5);
      start = 1'b1;
      n = cyc;
      s0 = n + 1;
      // restart with update disabled keeps 10/3
      for (int c = s0; c < s0 + 10; c++) push(c, 0, 1'b0, (c - s0) < 3, "R9");
      // update enabled from n+4: wrap at s0+10 takes 6/5
      for (int c = s0 + 10; c < s0 + 22; c++) push(c, 0, 1'b0, ((c - s0 - 10) % 6) < 5, "R9");
      @(posedge clk); #1;
      start = 1'b0;
      repeat (3) @(posedge clk);
      #1 upd_en = 1'b1;
      repeat (25) @(posedge clk);
      wait (q.size() == 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule